// File: doc/BRIEF.md
# Command Engine Run/Stop Sequencer with Program Counter

This block decides when a command fetch engine runs and holds the program counter that engine fetches from. The engine fetches one 32-bit command word at a time. Decoding, memory access and the command datapath sit outside the block; they report to it only through strobes: a word was fetched, a command finished, a sleep command ran.

The run enable comes from the power controller. Software can take it over with an override bit, and then its own enable bit decides. When the enable drops, the engine finishes its current command and then halts. While the engine is halted, software may load a new word offset into the program counter. A synchronous clear pulse returns the sequencer to its initial state and reloads the counter from a base offset. When execution then starts, a restart pulse goes out so that sticky status flags elsewhere can clear on it. A sleep command sets a done flag and sends a one-cycle done pulse to the power controller.

Top module: `cmd_runstop`

## Requirements
- R1: The effective enable is `sw_en_i` while `sw_ovr_i` is 1 and `pwr_en_i` while `sw_ovr_i` is 0.
- R2: When the effective enable falls while running, `stopped_o` rises only in the cycle after a `cmd_done_i` or `sleep_i` strobe. Until then `running_o` stays 1. If the enable comes back first, the engine keeps running.
- R3: While `running_o` is 1, each `fetch_i` adds one word to the program counter, so `fetch_addr_o` grows by 4 one cycle later. `fetch_i` has no effect in any other state.
- R4: `fetch_addr_o` is {13'h400, 17-bit word offset, 2'b00}. Bits 31:19 always read 0x400 and bits 1:0 always read 0.
- R5: A `pc_wr_i` strobe loads `pc_wr_data_i` into the word offset only while `stopped_o` is 1. At any other time the write is dropped and `fetch_addr_o` is unchanged.
- R6: An accepted write sets `pc_loaded_o`. The flag clears when the engine leaves the stopped state.
- R7: `clear_i` returns the sequencer to its initial state (`running_o` and `stopped_o` both 0) and sets the offset to `base_ofs_i`, even with a command in progress. It also clears `pc_loaded_o`. In the initial state the offset follows `base_ofs_i`.
- R8: A `sleep_i` strobe while running sets `done_o` and gives one cycle of `done_pulse_o`. Outside the running state, `sleep_i` is ignored.
- R9: Leaving the initial state on an asserted effective enable starts execution at the base offset. In that same cycle `restart_o` pulses for one cycle and `done_o` clears. Nothing else clears `done_o`.
- R10: The stopped state is left on a rising edge of the effective enable. Execution resumes from the current offset, which is the loaded one if a write was accepted.
- R11: After reset, `running_o`, `stopped_o`, `pc_loaded_o`, `done_o`, `done_pulse_o` and `restart_o` are 0 and `fetch_addr_o` is 0x2000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en_i | input | 1 | Enable from the power controller |
| sw_en_i | input | 1 | Software enable |
| sw_ovr_i | input | 1 | Software takes over the enable |
| clear_i | input | 1 | Synchronous sequencer clear pulse |
| base_ofs_i | input | 17 | Base word offset for restarts |
| fetch_i | input | 1 | A command word was fetched |
| cmd_done_i | input | 1 | The current command finished |
| sleep_i | input | 1 | A sleep command executed |
| pc_wr_i | input | 1 | Software program counter write strobe |
| pc_wr_data_i | input | 17 | Word offset to load |
| fetch_addr_o | output | 32 | Full fetch address |
| running_o | output | 1 | Engine running or draining |
| stopped_o | output | 1 | Engine halted |
| pc_loaded_o | output | 1 | Counter was loaded by software |
| done_o | output | 1 | Sleep command seen since the last restart |
| done_pulse_o | output | 1 | One-cycle done pulse |
| restart_o | output | 1 | Execution restarted from the base offset |

## Verification
The bench targets these corner cases:
- The enable dropping with no completion strobe. A design that halts at once would raise `stopped_o` too early.
- A program counter write while running. A design that accepts it would move the fetch address.
- A write in the same cycle as the resuming enable edge. A design that mishandles it would leave `pc_loaded_o` set or lose the new offset.
- A clear pulse in the middle of a command with `done_o` set. A design that ties `done_o` to the clear, instead of to the restart, would drop the flag a cycle early.

Random toggling of both enable sources and the override checks that a lost rising edge never leaves the engine stuck halted.

// File: rtl/runstop_pkg.sv
package runstop_pkg;
    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_STOP  = 2'd3
    } run_state_e;
endpackage

// File: rtl/runstop_en_sel.sv
module runstop_en_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en_i,
    input  logic sw_en_i,
    input  logic sw_ovr_i,
    output logic eff_en_o,
    output logic en_rise_o
);
    typedef struct packed {
        logic en;
    } sel_t;

    sel_t sel_d, sel_q;

    always_comb begin
        eff_en_o  = sw_ovr_i ? sw_en_i : pwr_en_i;
        en_rise_o = eff_en_o && !sel_q.en;
        sel_d     = sel_q;
        sel_d.en  = eff_en_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end
endmodule

// File: rtl/runstop_fsm.sv
module runstop_fsm
    import runstop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       eff_en_i,
    input  logic       en_rise_i,
    input  logic       cmd_end_i,
    output run_state_e state_o,
    output logic       start_base_o,
    output logic       restart_o
);
    typedef struct packed {
        run_state_e state;
        logic       restart;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d         = fsm_q;
        fsm_d.restart = 1'b0;
        start_base_o  = 1'b0;
        if (clear_i) begin
            fsm_d.state = ST_INIT;
        end else begin
            unique case (fsm_q.state)
                ST_INIT: begin
                    if (eff_en_i) begin
                        fsm_d.state   = ST_RUN;
                        fsm_d.restart = 1'b1;
                        start_base_o  = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!eff_en_i) fsm_d.state = cmd_end_i ? ST_STOP : ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (eff_en_i)       fsm_d.state = ST_RUN;
                    else if (cmd_end_i) fsm_d.state = ST_STOP;
                end
                ST_STOP: begin
                    if (en_rise_i) fsm_d.state = ST_RUN;
                end
                default: fsm_d.state = ST_INIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{state: ST_INIT, restart: 1'b0};
        else        fsm_q <= fsm_d;
    end

    assign state_o   = fsm_q.state;
    assign restart_o = fsm_q.restart;

    AST_RESUME_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_q.state) == ST_STOP && fsm_q.state == ST_RUN) |-> $past(en_rise_i)); // R10
endmodule

// File: rtl/runstop_pc.sv
module runstop_pc
    import runstop_pkg::*;
#(
    parameter int OFS_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  run_state_e       state_i,
    input  logic             en_rise_i,
    input  logic             fetch_i,
    input  logic [OFS_W-1:0] base_i,
    input  logic             wr_i,
    input  logic [OFS_W-1:0] wr_data_i,
    output logic [OFS_W-1:0] ofs_o,
    output logic             loaded_o
);
    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        logic             loaded;
    } pc_t;

    pc_t pc_d, pc_q;
    logic active;

    always_comb begin
        active = (state_i == ST_RUN) || (state_i == ST_DRAIN);
        pc_d   = pc_q;
        if (clear_i) begin
            pc_d.ofs    = base_i;
            pc_d.loaded = 1'b0;
        end else begin
            unique case (state_i)
                ST_INIT: pc_d.ofs = base_i;
                ST_RUN, ST_DRAIN: begin
                    if (fetch_i) pc_d.ofs = pc_q.ofs + 1'b1;
                end
                ST_STOP: begin
                    if (wr_i) pc_d.ofs = wr_data_i;
                    if (en_rise_i)  pc_d.loaded = 1'b0;
                    else if (wr_i)  pc_d.loaded = 1'b1;
                end
                default: pc_d = pc_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign ofs_o    = pc_q.ofs;
    assign loaded_o = pc_q.loaded;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && $past(fetch_i) && !$past(clear_i)) |-> (pc_q.ofs == $past(pc_q.ofs) + 1'b1)); // R3
    AST_LOADED_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pc_q.loaded) |-> ($past(state_i) == ST_STOP)); // R6
endmodule

// File: rtl/runstop_done.sv
module runstop_done (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic sleep_i,
    input  logic start_base_i,
    output logic done_o,
    output logic pulse_o
);
    typedef struct packed {
        logic done;
        logic pulse;
    } done_t;

    done_t dn_d, dn_q;

    always_comb begin
        dn_d       = dn_q;
        dn_d.pulse = 1'b0;
        if (start_base_i) begin
            dn_d.done = 1'b0;
        end else if (active_i && sleep_i) begin
            dn_d.done  = 1'b1;
            dn_d.pulse = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dn_q <= '0;
        else        dn_q <= dn_d;
    end

    assign done_o  = dn_q.done;
    assign pulse_o = dn_q.pulse;

    AST_PULSE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_q.pulse |-> (dn_q.done && $past(sleep_i))); // R8
endmodule

// File: rtl/cmd_runstop.sv
module cmd_runstop
    import runstop_pkg::*;
#(
    parameter int              OFS_W  = 17,
    parameter int              HI_W   = 13,
    parameter logic [HI_W-1:0] HI_VAL = 13'h400,
    localparam int             ADDR_W = HI_W + OFS_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en_i,
    input  logic              sw_en_i,
    input  logic              sw_ovr_i,
    input  logic              clear_i,
    input  logic [OFS_W-1:0]  base_ofs_i,
    input  logic              fetch_i,
    input  logic              cmd_done_i,
    input  logic              sleep_i,
    input  logic              pc_wr_i,
    input  logic [OFS_W-1:0]  pc_wr_data_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              running_o,
    output logic              stopped_o,
    output logic              pc_loaded_o,
    output logic              done_o,
    output logic              done_pulse_o,
    output logic              restart_o
);
    logic             eff_en, en_rise, start_base;
    run_state_e       state;
    logic [OFS_W-1:0] ofs;

    runstop_en_sel u_en (
        .clk(clk), .rst_n(rst_n),
        .pwr_en_i(pwr_en_i), .sw_en_i(sw_en_i), .sw_ovr_i(sw_ovr_i),
        .eff_en_o(eff_en), .en_rise_o(en_rise)
    );

    runstop_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
        .eff_en_i(eff_en), .en_rise_i(en_rise),
        .cmd_end_i(cmd_done_i | sleep_i),
        .state_o(state), .start_base_o(start_base), .restart_o(restart_o)
    );

    runstop_pc #(.OFS_W(OFS_W)) u_pc (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .state_i(state),
        .en_rise_i(en_rise), .fetch_i(fetch_i), .base_i(base_ofs_i),
        .wr_i(pc_wr_i), .wr_data_i(pc_wr_data_i),
        .ofs_o(ofs), .loaded_o(pc_loaded_o)
    );

    runstop_done u_done (
        .clk(clk), .rst_n(rst_n),
        .active_i(running_o), .sleep_i(sleep_i), .start_base_i(start_base),
        .done_o(done_o), .pulse_o(done_pulse_o)
    );

    assign running_o    = (state == ST_RUN) || (state == ST_DRAIN);
    assign stopped_o    = (state == ST_STOP);
    assign fetch_addr_o = {HI_VAL, ofs, 2'b00};

    AST_STOP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped_o) |-> ($past(cmd_done_i || sleep_i) && !$past(eff_en))); // R2
    AST_RESTART_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> (!done_o && running_o)); // R9
    AST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running_o) && $past(pc_wr_i) && !$past(fetch_i) && !$past(clear_i))
            |-> $stable(fetch_addr_o)); // R5
endmodule

// File: tb/cmd_runstop_test.sv
module cmd_runstop_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_en_i = 0, sw_en_i = 0, sw_ovr_i = 0, clear_i = 0;
    logic [16:0] base_ofs_i = '0, pc_wr_data_i = '0;
    logic fetch_i = 0, cmd_done_i = 0, sleep_i = 0, pc_wr_i = 0;
    logic [31:0] fetch_addr_o;
    logic running_o, stopped_o, pc_loaded_o, done_o, done_pulse_o, restart_o;

    int nchecks = 0, nfails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cmd_runstop uut (
        .clk(clk), .rst_n(rst_n), .pwr_en_i(pwr_en_i), .sw_en_i(sw_en_i),
        .sw_ovr_i(sw_ovr_i), .clear_i(clear_i), .base_ofs_i(base_ofs_i),
        .fetch_i(fetch_i), .cmd_done_i(cmd_done_i), .sleep_i(sleep_i),
        .pc_wr_i(pc_wr_i), .pc_wr_data_i(pc_wr_data_i),
        .fetch_addr_o(fetch_addr_o), .running_o(running_o), .stopped_o(stopped_o),
        .pc_loaded_o(pc_loaded_o), .done_o(done_o), .done_pulse_o(done_pulse_o),
        .restart_o(restart_o)
    );

    // Expected state, computed from the requirements: 0 init, 1 run, 2 drain, 3 stop
    int          m_st;
    logic [16:0] m_pc;
    logic        m_ld, m_done, m_pulse, m_rst, m_en;

    function automatic logic [31:0] addr_of(input logic [16:0] ofs);
        return {13'h400, ofs, 2'b00};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_pc = '0; m_ld = 0; m_done = 0; m_pulse = 0; m_rst = 0; m_en = 0;
        end else begin
            logic eff, rise, cend, act, start;
            int   nst;
            eff   = sw_ovr_i ? sw_en_i : pwr_en_i;          // R1
            rise  = eff && !m_en;
            cend  = cmd_done_i || sleep_i;
            act   = (m_st == 1) || (m_st == 2);
            start = !clear_i && (m_st == 0) && eff;
            nst   = m_st;
            if (clear_i) nst = 0;
            else case (m_st)
                0: if (eff) nst = 1;
                1: if (!eff) nst = cend ? 3 : 2;
                2: if (eff) nst = 1; else if (cend) nst = 3;
                default: if (rise) nst = 1;
            endcase
            if (clear_i) begin
                m_pc = base_ofs_i; m_ld = 0;
            end else if (m_st == 0) m_pc = base_ofs_i;
            else if (act) begin
                if (fetch_i) m_pc = m_pc + 1'b1;
            end else begin
                if (pc_wr_i) m_pc = pc_wr_data_i;
                if (rise) m_ld = 0; else if (pc_wr_i) m_ld = 1;
            end
            m_pulse = 0;
            if (start) m_done = 0;
            else if (act && sleep_i) begin m_done = 1; m_pulse = 1; end
            m_rst = start;
            m_en  = eff;
            m_st  = nst;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R3 R4 R5 R7 fetch_addr", fetch_addr_o, addr_of(m_pc));
        check("R1 R2 running", 32'(running_o), 32'(m_st == 1 || m_st == 2));
        check("R2 R10 stopped", 32'(stopped_o), 32'(m_st == 3));
        check("R6 pc_loaded", 32'(pc_loaded_o), 32'(m_ld));
        check("R8 R9 done", 32'(done_o), 32'(m_done));
        check("R8 done_pulse", 32'(done_pulse_o), 32'(m_pulse));
        check("R9 restart", 32'(restart_o), 32'(m_rst));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        fetch_i = 0; cmd_done_i = 0; sleep_i = 0; pc_wr_i = 0; clear_i = 0;
    endtask

    initial begin
        void'($urandom(32'h0005_eed1));
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 addr", fetch_addr_o, 32'h2000_0000);
        check("R11 flags", {26'd0, running_o, stopped_o, pc_loaded_o, done_o, done_pulse_o, restart_o}, 32'd0);
        rst_n = 1;
        base_ofs_i = 17'd5; sw_ovr_i = 1; sw_en_i = 1;
        tick();
        check("R9 restart pulse", 32'(restart_o), 32'd1);
        check("R4 base addr", fetch_addr_o, 32'h2000_0014);
        fetch_i = 1; tick(); fetch_i = 1; tick();
        check("R3 two fetches", fetch_addr_o, 32'h2000_001C);
        sw_en_i = 0; tick();
        check("R2 draining not stopped", {30'd0, running_o, stopped_o}, 32'd2);
        cmd_done_i = 1; tick();
        check("R2 stopped after done", 32'(stopped_o), 32'd1);
        fetch_i = 1; tick();
        check("R3 fetch ignored when stopped", fetch_addr_o, 32'h2000_001C);
        pc_wr_i = 1; pc_wr_data_i = 17'h100; tick();
        check("R5 write accepted", fetch_addr_o, 32'h2000_0400);
        check("R6 loaded set", 32'(pc_loaded_o), 32'd1);
        sw_en_i = 1; tick();
        check("R10 resumed", 32'(running_o), 32'd1);
        check("R10 resume offset", fetch_addr_o, 32'h2000_0400);
        check("R6 loaded cleared", 32'(pc_loaded_o), 32'd0);
        pc_wr_i = 1; pc_wr_data_i = 17'h1234; tick();
        check("R5 write dropped while running", fetch_addr_o, 32'h2000_0400);
        sleep_i = 1; tick();
        check("R8 done and pulse", {30'd0, done_o, done_pulse_o}, 32'd3);
        tick();
        check("R8 pulse one cycle", {30'd0, done_o, done_pulse_o}, 32'd2);
        sw_ovr_i = 0; pwr_en_i = 1; tick();
        check("R1 hardware enable keeps running", 32'(running_o), 32'd1);
        clear_i = 1; base_ofs_i = 17'd9; tick();
        check("R7 clear to init", {30'd0, running_o, stopped_o}, 32'd0);
        check("R7 base reload", fetch_addr_o, 32'h2000_0024);
        check("R9 done held over clear", 32'(done_o), 32'd1);
        tick();
        check("R9 done cleared on restart", {30'd0, done_o, restart_o}, 32'd1);
        // random phase
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 39) == 0)  pwr_en_i = ~pwr_en_i;
            if ($urandom_range(0, 29) == 0)  sw_en_i = ~sw_en_i;
            if ($urandom_range(0, 199) == 0) sw_ovr_i = ~sw_ovr_i;
            if ($urandom_range(0, 63) == 0)  base_ofs_i = 17'($urandom);
            clear_i      = ($urandom_range(0, 149) == 0);
            fetch_i      = ($urandom_range(0, 1) == 0);
            cmd_done_i   = ($urandom_range(0, 3) == 0);
            sleep_i      = ($urandom_range(0, 24) == 0);
            pc_wr_i      = ($urandom_range(0, 5) == 0);
            pc_wr_data_i = 17'($urandom);
            tick();
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
            $finish;
        end
    end

    initial begin
        #(1_000_000);
        if (!finished) begin
            finished = 1;
            nchecks++; nfails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
            $finish;
        end
    end
endmodule